// File: doc/BRIEF.md
# 100BASE-TX Transmit Line Encoder

This block turns the nibble-wide transmit stream from a media access controller into the single-wire symbol stream of a 100 Mbit/s twisted-pair link. It runs on one fast bit clock. An internal divide-by-five strobe marks the cycles in which a nibble and its frame-enable are taken in. Each nibble becomes a 5-bit code group. Frames are framed with start and end delimiters, and idle groups fill the gaps between frames.

Each code group is sent most significant bit first and XORed with an 11-bit scrambler stream. The scrambler's starting state depends on the port's management address, so that neighbouring ports in a switch spread their emissions differently. The result is NRZI coded and then mapped to a three-level MLT-3 output. A bypass control sends raw 5-bit groups with no coding, no delimiters and no scrambling.

Top module: `tx100_line_encoder`

## Requirements
- R1: While reset is high, `mlt3` is 0 and `nrzi` is 0. `nib_stb` is high in exactly one cycle out of every five, and the first of these is the first cycle after reset is released.
- R2: When `tx_en` is low and no frame is ending, the code group sent is 11111 (idle).
- R3: When `tx_en` is seen high after idle, the nibbles of that slot and the next slot are replaced by the start delimiter 11000 and then 10001. The second delimiter is sent even if `tx_en` has already dropped.
- R4: Every later nibble taken with `tx_en` high is sent as its 4B/5B group: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: The first slot in which `tx_en` is low after data sends 01101. The next slot sends 00111 whatever `tx_en` holds, and that slot's nibble is dropped. After that the encoder is idle again, and a high `tx_en` there starts a new frame.
- R6: The scrambler state is 11 bits and is loaded at reset with {`phy_addr`, 100001}; an all-zero value would be replaced by 1. Every bit clock the keystream bit is state[10] XOR state[8], and the state then shifts left with that bit entering at bit 0. The line bit is the code bit XOR the keystream bit.
- R7: `nrzi` toggles in exactly those clocks whose line bit is 1.
- R8: `mlt3` (2-bit signed) starts at 0. It steps through 0, +1, 0, −1, 0, … on each line bit of 1 and holds its level on a 0.
- R9: When `bypass` is high in a slot, that slot sends {`tx_en`, `txd`} unscrambled and inserts no delimiter. The choice is made per slot.
- R10: A slot's inputs are taken at the clock edge that ends a `nib_stb` cycle. The group's five bits reach `nrzi` and `mlt3` at the 2nd through 6th edges, counting that edge as the 1st.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock (one line bit per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| phy_addr | input | 5 | Management address, used for the scrambler seed at reset |
| bypass | input | 1 | Send raw 5-bit groups, unscrambled |
| tx_en | input | 1 | Frame enable from the MAC |
| txd | input | 4 | Transmit nibble |
| nib_stb | output | 1 | High in the cycle whose ending edge samples `tx_en`/`txd` |
| nrzi | output | 1 | NRZI-coded line bit |
| mlt3 | output | 2 | MLT-3 level, signed: −1, 0 or +1 |

## Verification
Every result lags its stimulus by a fixed count of edges. Inputs driven during a `nib_stb` cycle are loaded at that cycle's closing edge. Their code group then appears on the line one bit per edge over the following five edges, and each bit changes `nrzi` and `mlt3` in the same edge. The bench drives each slot one time unit after the falling edge of a strobe cycle. A monitor samples the outputs two time units after every falling edge, turns each `mlt3` change into a line bit, strips the keystream with its own seeded scrambler, and counts bits from the first edge after reset so that group n covers edges 5n+2 to 5n+6. A dedicated test confirms this latency directly: the load edge leaves the line unchanged and the next edge carries the first bit.

// File: rtl/tx100_pkg.sv
package tx100_pkg;

    localparam int NIB_W     = 4;
    localparam int SYM_W     = NIB_W + 1;
    localparam int ADDR_W    = 5;
    localparam int LFSR_W    = 11;
    localparam int LFSR_TAP  = 9;
    localparam int SEED_LO_W = LFSR_W - ADDR_W;
    localparam logic [SEED_LO_W-1:0] SEED_LO = 6'b100001;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t SYM_IDLE = 5'b11111;
    localparam sym_t SYM_SSD1 = 5'b11000;
    localparam sym_t SYM_SSD2 = 5'b10001;
    localparam sym_t SYM_ESD1 = 5'b01101;
    localparam sym_t SYM_ESD2 = 5'b00111;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SSD2,
        FR_DATA,
        FR_ESD2
    } frame_st_e;

    typedef struct packed {
        sym_t bits;
        logic raw;
    } group_t;

    function automatic sym_t enc_4b5b(input logic [NIB_W-1:0] n);
        sym_t s;
        case (n)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            default: s = 5'b11101;
        endcase
        return s;
    endfunction

    function automatic logic signed [1:0] mlt3_level(input logic [1:0] ph);
        logic signed [1:0] l;
        case (ph)
            2'd1:    l = 2'sb01;
            2'd3:    l = 2'sb11;
            default: l = 2'sb00;
        endcase
        return l;
    endfunction

    function automatic logic [LFSR_W-1:0] make_seed(input logic [ADDR_W-1:0] a);
        logic [LFSR_W-1:0] s;
        s = {a, SEED_LO};
        if (s == '0) s = LFSR_W'(1);
        return s;
    endfunction

endpackage

// File: rtl/tx100_framer.sv
module tx100_framer
    import tx100_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic             tx_en,
    input  logic [NIB_W-1:0] txd,
    input  logic             bypass,
    output group_t           grp
);

    frame_st_e st, st_nxt;

    always_comb begin
        st_nxt   = st;
        grp.bits = SYM_IDLE;
        grp.raw  = 1'b0;
        if (bypass) begin
            grp.bits = sym_t'({tx_en, txd});
            grp.raw  = 1'b1;
            st_nxt   = FR_IDLE;
        end else begin
            case (st)
                FR_IDLE: begin
                    if (tx_en) begin
                        grp.bits = SYM_SSD1;
                        st_nxt   = FR_SSD2;
                    end
                end
                FR_SSD2: begin
                    grp.bits = SYM_SSD2;
                    st_nxt   = FR_DATA;
                end
                FR_DATA: begin
                    if (tx_en) begin
                        grp.bits = enc_4b5b(txd);
                    end else begin
                        grp.bits = SYM_ESD1;
                        st_nxt   = FR_ESD2;
                    end
                end
                default: begin
                    grp.bits = SYM_ESD2;
                    st_nxt   = FR_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)     st <= FR_IDLE;
        else if (ld) st <= st_nxt;
    end

endmodule

// File: rtl/tx100_serializer.sv
module tx100_serializer
    import tx100_pkg::*;
#(
    parameter int SW = SYM_W
) (
    input  logic   clk,
    input  logic   rst,
    input  group_t grp,
    output logic   ld,
    output logic   bit_o,
    output logic   raw_o
);

    localparam int CNT_W = $clog2(SW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SW - 1);

    logic [CNT_W-1:0] cnt;
    sym_t             sh;
    logic             raw;

    assign ld    = (cnt == '0);
    assign bit_o = sh[SYM_W-1];
    assign raw_o = raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sh  <= '1;
            raw <= 1'b0;
        end else begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (ld) begin
                sh  <= grp.bits;
                raw <= grp.raw;
            end else begin
                sh  <= {sh[SYM_W-2:0], 1'b0};
            end
        end
    end

endmodule

// File: rtl/tx100_scrambler.sv
module tx100_scrambler
    import tx100_pkg::*;
#(
    parameter int LW  = LFSR_W,
    parameter int TAP = LFSR_TAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    output logic              ks
);

    logic [LW-1:0] st;

    assign ks = st[LW-1] ^ st[TAP-1];

    always_ff @(posedge clk) begin
        if (rst) st <= LW'(make_seed(addr));
        else     st <= {st[LW-2:0], ks};
    end

endmodule

// File: rtl/tx100_line.sv
module tx100_line
    import tx100_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_i,
    output logic              nrzi_o,
    output logic signed [1:0] mlt3_o
);

    logic [1:0] ph;

    assign mlt3_o = mlt3_level(ph);

    always_ff @(posedge clk) begin
        if (rst) begin
            nrzi_o <= 1'b0;
            ph     <= 2'd0;
        end else begin
            nrzi_o <= nrzi_o ^ bit_i;
            ph     <= ph + {1'b0, bit_i};
        end
    end

endmodule

// File: rtl/tx100_line_encoder.sv
module tx100_line_encoder
    import tx100_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        phy_addr,
    input  logic              bypass,
    input  logic              tx_en,
    input  logic [3:0]        txd,
    output logic              nib_stb,
    output logic              nrzi,
    output logic signed [1:0] mlt3
);

    group_t grp;
    logic   ld, code_bit, raw_bit, ks, line_bit;

    tx100_framer u_framer (
        .clk    (clk),
        .rst    (rst),
        .ld     (ld),
        .tx_en  (tx_en),
        .txd    (txd),
        .bypass (bypass),
        .grp    (grp)
    );

    tx100_serializer #(.SW(SYM_W)) u_ser (
        .clk   (clk),
        .rst   (rst),
        .grp   (grp),
        .ld    (ld),
        .bit_o (code_bit),
        .raw_o (raw_bit)
    );

    tx100_scrambler #(.LW(LFSR_W), .TAP(LFSR_TAP)) u_scr (
        .clk  (clk),
        .rst  (rst),
        .addr (phy_addr),
        .ks   (ks)
    );

    assign line_bit = code_bit ^ (ks & ~raw_bit);

    tx100_line u_line (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (line_bit),
        .nrzi_o (nrzi),
        .mlt3_o (mlt3)
    );

    assign nib_stb = ld;

endmodule

// File: rtl/tx100_line_encoder_chk.sv
module tx100_line_encoder_chk
    import tx100_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              nib_stb,
    input logic              nrzi,
    input logic signed [1:0] mlt3
);

    localparam int GW = $clog2(SYM_W + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(SYM_W);

    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst)          gap <= GAP_FULL;
        else if (nib_stb) gap <= GW'(1);
        else              gap <= gap + 1'b1;
    end

    assert_stb_period_R1: assert property (@(posedge clk) disable iff (rst)
        nib_stb == (gap == GAP_FULL));

    assert_mlt3_range_R8: assert property (@(posedge clk) disable iff (rst)
        mlt3 != 2'sb10);

    assert_mlt3_step_R8: assert property (@(posedge clk) disable iff (rst)
        (mlt3 != $past(mlt3)) |-> (mlt3 == 2'sb00 || $past(mlt3) == 2'sb00));

    assert_nrzi_follows_R7: assert property (@(posedge clk) disable iff (rst)
        (nrzi != $past(nrzi)) == (mlt3 != $past(mlt3)));

endmodule

bind tx100_line_encoder tx100_line_encoder_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .nib_stb (nib_stb),
    .nrzi    (nrzi),
    .mlt3    (mlt3)
);

// File: tb/test_tx100_line_encoder.sv
module test_tx100_line_encoder;

    localparam int CLK_P = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [4:0]        phy_addr = 5'h0A;
    logic              bypass = 1'b0;
    logic              tx_en = 1'b0;
    logic [3:0]        txd = 4'h0;
    logic              nib_stb;
    logic              nrzi;
    logic signed [1:0] mlt3;

    int total = 0;
    int bad   = 0;

    tx100_line_encoder i_tx100_line_encoder (
        .clk      (clk),
        .rst      (rst),
        .phy_addr (phy_addr),
        .bypass   (bypass),
        .tx_en    (tx_en),
        .txd      (txd),
        .nib_stb  (nib_stb),
        .nrzi     (nrzi),
        .mlt3     (mlt3)
    );

    always #(CLK_P/2) clk = ~clk;

    // ---- bench-side model pieces taken from the requirements ----
    function automatic logic [10:0] seed_of(input logic [4:0] a);
        logic [10:0] s;
        s = {a, 6'b100001};
        if (s == 11'd0) s = 11'd1;
        return s;
    endfunction

    function automatic logic [4:0] code_of(input logic [3:0] n);
        logic [4:0] t [16];
        t = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011,
              5'b01110, 5'b01111, 5'b10010, 5'b10011, 5'b10110, 5'b10111,
              5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---- line monitor: recovers descrambled code groups ----
    logic [10:0] b_lfsr;
    logic [4:0]  asm_g;
    logic [4:0]  rx_g  [0:1023];
    logic        exp_b [0:1023];
    int n_edge, n_rx, n_exp, prev_m, last_nz, mlt_bad, nrzi_bad;
    logic prev_n, prev_rst;

    initial begin
        prev_rst = 1'b1;
        mlt_bad  = 0;
        nrzi_bad = 0;
        n_rx     = 0;
        n_exp    = 0;
        forever begin
            @(negedge clk);
            #2;
            if (rst) begin
                b_lfsr  = seed_of(phy_addr);
                n_edge  = 0;
                n_rx    = 0;
                n_exp   = 0;
                prev_m  = 0;
                prev_n  = 1'b0;
                last_nz = -1;
                asm_g   = 5'd0;
            end else begin
                if (!prev_rst) begin
                    int   cur, g, p;
                    logic t, ks, bv;
                    cur = int'(mlt3);
                    t   = (cur != prev_m);
                    if (t) begin
                        if (prev_m == 0) begin
                            if (cur != -last_nz) mlt_bad++;
                            last_nz = cur;
                        end else if (cur != 0) begin
                            mlt_bad++;
                        end
                    end
                    if ((nrzi != prev_n) != t) nrzi_bad++;
                    ks     = b_lfsr[10] ^ b_lfsr[8];
                    b_lfsr = {b_lfsr[9:0], ks};
                    n_edge++;
                    if (n_edge >= 2) begin
                        g  = (n_edge - 2) / 5;
                        p  = (n_edge - 2) % 5;
                        bv = t ^ (ks & ~exp_b[g]);
                        asm_g = {asm_g[3:0], bv};
                        if (p == 4) begin
                            rx_g[g] = asm_g;
                            n_rx    = g + 1;
                        end
                    end
                    prev_m = cur;
                    prev_n = nrzi;
                end
                if (nib_stb) begin
                    exp_b[n_exp] = bypass;
                    n_exp++;
                end
            end
            prev_rst = rst;
        end
    end

    // ---- drivers ----
    task automatic do_reset(input logic [4:0] a);
        @(negedge clk);
        rst = 1'b1; tx_en = 1'b0; txd = 4'h0; bypass = 1'b0; phy_addr = a;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic slot(input logic en, input logic [3:0] d, input logic b, output int idx);
        @(negedge clk);
        while (!nib_stb) @(negedge clk);
        #1;
        tx_en = en; txd = d; bypass = b;
        idx = n_exp;
    endtask

    task automatic wait_grp(input int idx);
        wait (n_rx > idx);
    endtask

    // ---- scenarios ----
    task automatic t_reset();
        int ones, first;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk("R1 mlt3 in reset", int'(mlt3), 0);
        chk("R1 nrzi in reset", int'(nrzi), 0);
        rst = 1'b0;
        #1;
        first = int'(nib_stb);
        ones  = first;
        for (int c = 1; c < 10; c++) begin
            @(negedge clk); #1;
            ones += int'(nib_stb);
        end
        chk("R1 strobe in first cycle", first, 1);
        chk("R1 strobes per ten cycles", ones, 2);
    endtask

    task automatic t_idle(input logic [4:0] a, input string tag);
        int idx, last;
        do_reset(a);
        last = 0;
        for (int i = 0; i < 6; i++) slot(1'b0, 4'h0, 1'b0, last);
        wait_grp(last);
        for (int i = 1; i <= last; i++)
            chk(tag, int'(rx_g[i]), int'(5'b11111));
        idx = last;
    endtask

    task automatic t_frame();
        int ij, ik, it, ir, ii;
        int id [16];
        do_reset(5'h0A);
        slot(1'b0, 4'h0, 1'b0, ij);
        slot(1'b1, 4'h5, 1'b0, ij);
        slot(1'b1, 4'h5, 1'b0, ik);
        for (int n = 0; n < 16; n++) slot(1'b1, 4'(n), 1'b0, id[n]);
        slot(1'b0, 4'h0, 1'b0, it);
        slot(1'b0, 4'h0, 1'b0, ir);
        slot(1'b0, 4'h0, 1'b0, ii);
        wait_grp(ii);
        chk("R3 first delimiter", int'(rx_g[ij]), int'(5'b11000));
        chk("R3 second delimiter", int'(rx_g[ik]), int'(5'b10001));
        for (int n = 0; n < 16; n++)
            chk("R4 nibble code", int'(rx_g[id[n]]), int'(code_of(4'(n))));
        chk("R5 end delimiter T", int'(rx_g[it]), int'(5'b01101));
        chk("R5 end delimiter R", int'(rx_g[ir]), int'(5'b00111));
        chk("R2 idle after frame", int'(rx_g[ii]), int'(5'b11111));
    endtask

    task automatic t_r_slot_ignored();
        int a, b, c, t, r, j, k;
        do_reset(5'h0A);
        slot(1'b1, 4'h5, 1'b0, a);
        slot(1'b1, 4'h5, 1'b0, b);
        slot(1'b1, 4'h9, 1'b0, c);
        slot(1'b0, 4'h0, 1'b0, t);
        slot(1'b1, 4'h3, 1'b0, r);
        slot(1'b1, 4'h5, 1'b0, j);
        slot(1'b1, 4'h5, 1'b0, k);
        slot(1'b0, 4'h0, 1'b0, k);
        wait_grp(k);
        chk("R4 data before end", int'(rx_g[c]), int'(5'b10011));
        chk("R5 R slot drops nibble", int'(rx_g[r]), int'(5'b00111));
        chk("R5 new frame after R", int'(rx_g[j]), int'(5'b11000));
    endtask

    task automatic t_short();
        int j, k, t, r, i;
        do_reset(5'h0A);
        slot(1'b1, 4'h5, 1'b0, j);
        slot(1'b0, 4'h0, 1'b0, k);
        slot(1'b0, 4'h0, 1'b0, t);
        slot(1'b0, 4'h0, 1'b0, r);
        slot(1'b0, 4'h0, 1'b0, i);
        wait_grp(i);
        chk("R3 one-slot frame J", int'(rx_g[j]), int'(5'b11000));
        chk("R3 K sent after drop", int'(rx_g[k]), int'(5'b10001));
        chk("R5 T after K", int'(rx_g[t]), int'(5'b01101));
        chk("R5 R after T", int'(rx_g[r]), int'(5'b00111));
        chk("R2 idle after short frame", int'(rx_g[i]), int'(5'b11111));
    endtask

    task automatic t_bypass();
        int id [8];
        logic [4:0] pat [8];
        int last;
        pat = '{5'b10000, 5'b11010, 5'b00101, 5'b11111, 5'b00000, 5'b10111, 5'b01100, 5'b10011};
        do_reset(5'h0A);
        for (int n = 0; n < 8; n++) slot(pat[n][4], pat[n][3:0], 1'b1, id[n]);
        slot(1'b0, 4'h0, 1'b0, last);
        slot(1'b0, 4'h0, 1'b0, last);
        wait_grp(last);
        for (int n = 0; n < 8; n++)
            chk("R9 raw group", int'(rx_g[id[n]]), int'(pat[n]));
        chk("R9 back to coded idle", int'(rx_g[last]), int'(5'b11111));
    endtask

    task automatic t_latency();
        int idx, m0, n0;
        do_reset(5'h0A);
        for (int i = 0; i < 3; i++) slot(1'b0, 4'h0, 1'b1, idx);
        slot(1'b1, 4'hF, 1'b1, idx);
        m0 = int'(mlt3);
        n0 = int'(nrzi);
        @(negedge clk); #1;
        chk("R10 load edge leaves line", int'(mlt3), m0);
        @(negedge clk); #1;
        chk("R10 first bit on next edge mlt3", int'(mlt3 != 2'(m0)), 1);
        chk("R10 first bit on next edge nrzi", int'(nrzi), 1 - n0);
        slot(1'b0, 4'h0, 1'b0, idx);
    endtask

    task automatic t_line();
        chk("R8 mlt3 sequence violations", mlt_bad, 0);
        chk("R7 nrzi vs line bit mismatches", nrzi_bad, 0);
    endtask

    // ---- watchdog ----
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_idle(5'h0A, "R2 idle group");
        t_idle(5'h13, "R6 seed from address 13");
        t_idle(5'h00, "R6 seed from address 0");
        t_frame();
        t_r_slot_ignored();
        t_short();
        t_bypass();
        t_latency();
        t_line();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule